// File: doc/BRIEF.md
# Shared Pin Function Register Bank

This block holds the configuration and readback state for 32 shared pins, each of which can serve as an analog converter input, a general-purpose input, or a general-purpose output. The pins form two banks of sixteen, A and B. Logical pins 0 to 15 are A0 to A15, and pins 16 to 31 are B0 to B15. A host writes and reads the state through a plain address/data port. The block drives per-pin output-enable, output-value and input-enable lines toward the pads. It also reports which pins are currently taken away from the analog path.

Sixteen eight-bit registers make up the bank, in four groups of four: sampled input values, input enables, output enables and output values. Within a group the registers sit in reversed order, so the lowest pins occupy the highest offset. Input values are captured through a synchronizer and are never writable.

Top module: `pinmux_regbank`

## Requirements
- R1: After reset, every enable and output-value bit is 0, so gpio_mode_o, pin_oe_o, pin_ie_o and pin_out_o are all zero and every pin is analog.
- R2: An access hits the bank only when addr_i[5] is 1, and addr_i[3:0] selects the register. addr_i[4] is not decoded. A write with addr_i[5]=0 changes nothing, and a read with addr_i[5]=0 returns 0x00.
- R3: Offsets 0x0-0x3 hold sampled input values, 0x4-0x7 input enables, 0x8-0xB output enables and 0xC-0xF output values.
- R4: In each group, offset base+3 holds pins 0-7, base+2 holds pins 8-15, base+1 holds pins 16-23 and base+0 holds pins 24-31. Pin n sits at bit n mod 8.
- R5: A write to an enable or output-value register takes effect at the clock edge where we_i is sampled high, and a read of that register returns the value written. rdata_o is combinational from addr_i.
- R6: Writes to input-value registers have no effect on any register.
- R7: A change on pin_in_i becomes visible on rdata_o after two rising clock edges.
- R8: A pin with its output-enable bit set drives pin_oe_o=1 and pin_out_o equal to its output-value bit. A pin with only its input-enable bit set gives pin_ie_o=1 and pin_oe_o=0. A pin with both bits clear has gpio_mode_o=0, pin_oe_o=0 and pin_out_o=0.
- R9: A pin with both enable bits set behaves as an output: pin_oe_o=1 and pin_ie_o=0.
- R10: Writing 0x00 to all eight enable registers returns every pin to analog mode, so gpio_mode_o becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 6 | Register address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| pin_in_i | input | 32 | Live pin levels |
| pin_oe_o | output | 32 | Per-pin output enable |
| pin_out_o | output | 32 | Per-pin output level |
| pin_ie_o | output | 32 | Per-pin input enable |
| gpio_mode_o | output | 32 | 1 when the pin is in GPIO mode, 0 when it is analog |

## Verification
A write to an input-value register can land on the same clock edge at which the pin levels change. The bench provokes this by driving a write to offset 0x0 and a new pin_in_i pattern in the same cycle. Two things are then judged. The synchronizer must still carry the new pin level to rdata_o two edges later, and the write data must not appear. All enable registers must also read back unchanged.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    GRP_IVAL = 2'd0,
    GRP_IEN  = 2'd1,
    GRP_OEN  = 2'd2,
    GRP_OVAL = 2'd3
  } grp_e;
endpackage

// File: rtl/pinmux_sync.sv
module pinmux_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= '0;
    else         stage_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];

  // R7
  sync_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_o == $past(stage_q[STAGES-2]));
endmodule

// File: rtl/pinmux_decode.sv
module pinmux_decode
  import pinmux_pkg::*;
#(
  parameter int unsigned ADDR_W    = 6,
  parameter int unsigned NUM_BYTES = 4
) (
  input  logic [ADDR_W-1:0]    addr_i,
  output logic                 hit_o,
  output grp_e                 grp_o,
  output logic [NUM_BYTES-1:0] byte_sel_o
);
  localparam int unsigned IDX_W = $clog2(NUM_BYTES);

  logic [IDX_W-1:0] idx;

  assign hit_o = addr_i[ADDR_W-1];
  assign grp_o = grp_e'(addr_i[IDX_W+1:IDX_W]);
  assign idx   = addr_i[IDX_W-1:0];

  // reversed order: highest offset holds the lowest pins
  always_comb begin
    byte_sel_o = '0;
    for (int b = 0; b < NUM_BYTES; b++) begin
      if (idx == IDX_W'(NUM_BYTES - 1 - b)) byte_sel_o[b] = 1'b1;
    end
  end

  // R4
  byte_sel_chk: assert property (@(addr_i) hit_o |-> $countones(byte_sel_o) == 1);
endmodule

// File: rtl/pinmux_slice.sv
module pinmux_slice
  import pinmux_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_ien_i,
  input  logic              wr_oen_i,
  input  logic              wr_oval_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] ien_o,
  output logic [BYTE_W-1:0] oen_o,
  output logic [BYTE_W-1:0] oval_o,
  output logic [BYTE_W-1:0] pin_oe_o,
  output logic [BYTE_W-1:0] pin_out_o,
  output logic [BYTE_W-1:0] pin_ie_o,
  output logic [BYTE_W-1:0] gpio_mode_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ien_o  <= '0;
      oen_o  <= '0;
      oval_o <= '0;
    end else begin
      if (wr_ien_i)  ien_o  <= wdata_i;
      if (wr_oen_i)  oen_o  <= wdata_i;
      if (wr_oval_i) oval_o <= wdata_i;
    end
  end

  // output enable wins over input enable
  assign pin_oe_o    = oen_o;
  assign pin_out_o   = oval_o & oen_o;
  assign pin_ie_o    = ien_o & ~oen_o;
  assign gpio_mode_o = ien_o | oen_o;

  // R5
  wr_oen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_oen_i |=> oen_o == $past(wdata_i));

  // R5
  wr_ien_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ien_i |=> ien_o == $past(wdata_i));

  // R6
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_ien_i || wr_oen_i || wr_oval_i) |=> $stable({ien_o, oen_o, oval_o}));

  // R8
  analog_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((~gpio_mode_o) & (pin_oe_o | pin_ie_o | pin_out_o)) == '0);
endmodule

// File: rtl/pinmux_regbank.sv
module pinmux_regbank
  import pinmux_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 32,
  parameter int unsigned ADDR_W      = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                we_i,
  input  logic [BYTE_W-1:0]   wdata_i,
  output logic [BYTE_W-1:0]   rdata_o,
  input  logic [NUM_PINS-1:0] pin_in_i,
  output logic [NUM_PINS-1:0] pin_oe_o,
  output logic [NUM_PINS-1:0] pin_out_o,
  output logic [NUM_PINS-1:0] pin_ie_o,
  output logic [NUM_PINS-1:0] gpio_mode_o
);
  localparam int unsigned NUM_BYTES = NUM_PINS / BYTE_W;

  logic                 hit;
  grp_e                 grp;
  logic [NUM_BYTES-1:0] byte_sel;
  logic [NUM_PINS-1:0]  ival_q, ien_q, oen_q, oval_q;

  pinmux_decode #(.ADDR_W(ADDR_W), .NUM_BYTES(NUM_BYTES)) i_decode (
    .addr_i     (addr_i),
    .hit_o      (hit),
    .grp_o      (grp),
    .byte_sel_o (byte_sel)
  );

  pinmux_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_in_i),
    .q_o    (ival_q)
  );

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_slice
    logic wr_b;
    assign wr_b = we_i & hit & byte_sel[b];

    pinmux_slice i_slice (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_ien_i    (wr_b & (grp == GRP_IEN)),
      .wr_oen_i    (wr_b & (grp == GRP_OEN)),
      .wr_oval_i   (wr_b & (grp == GRP_OVAL)),
      .wdata_i     (wdata_i),
      .ien_o       (ien_q[b*BYTE_W +: BYTE_W]),
      .oen_o       (oen_q[b*BYTE_W +: BYTE_W]),
      .oval_o      (oval_q[b*BYTE_W +: BYTE_W]),
      .pin_oe_o    (pin_oe_o[b*BYTE_W +: BYTE_W]),
      .pin_out_o   (pin_out_o[b*BYTE_W +: BYTE_W]),
      .pin_ie_o    (pin_ie_o[b*BYTE_W +: BYTE_W]),
      .gpio_mode_o (gpio_mode_o[b*BYTE_W +: BYTE_W])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (hit) begin
      for (int b = 0; b < NUM_BYTES; b++) begin
        if (byte_sel[b]) begin
          unique case (grp)
            GRP_IVAL: rdata_o = ival_q[b*BYTE_W +: BYTE_W];
            GRP_IEN:  rdata_o = ien_q[b*BYTE_W +: BYTE_W];
            GRP_OEN:  rdata_o = oen_q[b*BYTE_W +: BYTE_W];
            default:  rdata_o = oval_q[b*BYTE_W +: BYTE_W];
          endcase
        end
      end
    end
  end

  // R1
  reset_dflt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (gpio_mode_o == '0 && pin_oe_o == '0 && pin_out_o == '0));

  // R6
  ro_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && hit && grp == GRP_IVAL) |=> $stable({ien_q, oen_q, oval_q}));

  // R2
  miss_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !hit) |=> $stable({ien_q, oen_q, oval_q}));

  // R2
  miss_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit |-> rdata_o == '0);
endmodule

// File: tb/test_pinmux_regbank.sv
module test_pinmux_regbank;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [5:0]  addr = '0;
  logic        we = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_oe, pin_out, pin_ie, gpio_mode;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #10 clk = ~clk;

  pinmux_regbank i_pinmux_regbank (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .addr_i      (addr),
    .we_i        (we),
    .wdata_i     (wdata),
    .rdata_o     (rdata),
    .pin_in_i    (pin_in),
    .pin_oe_o    (pin_oe),
    .pin_out_o   (pin_out),
    .pin_ie_o    (pin_ie),
    .gpio_mode_o (gpio_mode)
  );

  // monitor: kind 0 rdata, 1 pin_oe, 2 pin_out, 3 pin_ie, 4 gpio_mode
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sb_q.pop_front();
      case (it.kind)
        0:       act = {24'h0, rdata};
        1:       act = pin_oe;
        2:       act = pin_out;
        3:       act = pin_ie;
        default: act = gpio_mode;
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s kind %0d actual %h expected %h", it.tag, it.kind, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(posedge clk); #2;
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #2;
    we = 1'b0;
  endtask

  task automatic wr_pins(input logic [5:0] a, input logic [7:0] d, input logic [31:0] p);
    @(posedge clk); #2;
    we = 1'b1; addr = a; wdata = d; pin_in = p;
    @(posedge clk); #2;
    we = 1'b0;
  endtask

  task automatic set_pins(input logic [31:0] p);
    @(posedge clk); #2;
    pin_in = p;
  endtask

  task automatic chk_rd(input logic [5:0] a, input logic [7:0] e, input string tag);
    @(posedge clk); #2;
    addr = a;
    sb_q.push_back('{0, {24'h0, e}, tag});
    @(negedge clk); #1;
  endtask

  task automatic chk_pin(input int kind, input logic [31:0] e, input string tag);
    @(posedge clk); #2;
    sb_q.push_back('{kind, e, tag});
    @(negedge clk); #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_ni = 1'b1;

    // R1 reset state
    chk_pin(4, 32'h0, "R1");
    chk_pin(1, 32'h0, "R1");
    chk_pin(2, 32'h0, "R1");
    chk_rd(6'h27, 8'h00, "R1");
    chk_rd(6'h2F, 8'h00, "R1");

    // R5 R4 input enables, both banks
    wr(6'h27, 8'hA5);
    wr(6'h24, 8'h3C);
    chk_rd(6'h27, 8'hA5, "R5");
    chk_rd(6'h24, 8'h3C, "R5");
    chk_pin(3, 32'h3C0000A5, "R4");
    chk_pin(4, 32'h3C0000A5, "R8");

    // R8 output on pins 12-15
    wr(6'h2A, 8'hF0);
    wr(6'h2E, 8'hFF);
    chk_pin(1, 32'h0000F000, "R8");
    chk_pin(2, 32'h0000F000, "R8");

    // R9 both enables on pins 0 and 2
    wr(6'h2B, 8'h0F);
    wr(6'h2F, 8'h05);
    chk_pin(1, 32'h0000F00F, "R9");
    chk_pin(3, 32'h3C0000A0, "R9");
    chk_pin(2, 32'h0000F005, "R8");
    chk_pin(4, 32'h3C00F0AF, "R8");
    chk_rd(6'h2E, 8'hFF, "R3");

    // R2 decode
    chk_rd(6'h3B, 8'h0F, "R2");
    wr(6'h0B, 8'hFF);
    chk_rd(6'h2B, 8'h0F, "R2");
    chk_rd(6'h0B, 8'h00, "R2");

    // R7 sync latency, R3 R4 placement of input bytes
    set_pins(32'hDEADBEEF);
    chk_rd(6'h23, 8'h00, "R7");
    chk_rd(6'h23, 8'hEF, "R7");
    chk_rd(6'h22, 8'hBE, "R4");
    chk_rd(6'h21, 8'hAD, "R4");
    chk_rd(6'h20, 8'hDE, "R3");

    // R6 write to input-value register while pins change
    wr_pins(6'h20, 8'h55, 32'h12345678);
    chk_rd(6'h20, 8'h12, "R6");
    chk_rd(6'h23, 8'h78, "R7");
    chk_rd(6'h2B, 8'h0F, "R6");
    chk_rd(6'h27, 8'hA5, "R6");
    chk_rd(6'h2F, 8'h05, "R6");

    // R10 clear all eight enables
    for (int i = 0; i < 8; i++) wr(6'h24 + 6'(i), 8'h00);
    chk_pin(4, 32'h0, "R10");
    chk_pin(1, 32'h0, "R10");
    chk_pin(3, 32'h0, "R10");
    chk_pin(2, 32'h0, "R10");

    @(posedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule